// File: doc/BRIEF.md
# Shared SMBus Semaphore and Port Router

This block lets two agents take turns at a single SMBus master: the host processor and an embedded management microcontroller. The host asks for the bus by writing a request bit in a small semaphore register. It learns whether it owns the bus by reading that same bit back, and gives the bus up by writing a separate release bit. The microcontroller has a level request input, a release pulse input and a grant output. Once one side owns the bus, the other side's requests are ignored until the owner releases.

The same block steers the master's clock and data lines to one of four downstream port pairs. The routing code sits in a two-bit field of a configuration register, which is reached through an index/data register pair. A bit in a third configuration register decides which of two registers supplies the code. Port pairs not selected see both lines released high. A code change requested while the engine reports a transfer in flight is refused, so a transfer never moves to another port partway through. Software usually saves the select register, rewrites it for its transfer, then writes the saved byte back. Every write stores the whole byte, so this save and restore leaves the other bits untouched.

Top module: `smb_share_mux`

## Requirements
- R1: After reset, the semaphore reads 0x00, mcu_grant is 0, port_sel_o is 0, phys_port_o is 0, and with the engine lines released every port output is high.
- R2: A host write to address 0 with bit 4 set, while nobody owns the bus, makes the host owner. A read of address 0 returns bit 4 = 1 while the host owns the bus and 0 otherwise, and all other bits read 0.
- R3: A host write to address 0 with bit 5 set frees the bus when the host owns it. If bits 4 and 5 are set in the same write, the release wins and no grant results.
- R4: When the bus is free and mcu_req is high, the microcontroller becomes owner on that edge, even if the host requests in the same cycle. mcu_grant then reads 1 and the host bit reads 0.
- R5: A grant holds until its owner releases it. mcu_req is ignored while the host owns the bus, host requests are ignored while the microcontroller owns it, and an mcu_rel pulse frees the microcontroller's grant.
- R6: The routing code is bits 2:1 of the chosen select register and appears on port_sel_o. Codes 0, 1, 2 and 3 report physical port numbers 0, 2, 3 and 4 on phys_port_o. Number 1 is never produced, because that slot belongs to a separate auxiliary controller.
- R7: The selected port's outputs follow eng_scl_o and eng_sda_o, unselected port outputs stay 1, and eng_scl_i and eng_sda_i return the selected port's inputs.
- R8: Bit 0 of configuration index 0x2F picks the select register: 0 picks index 0x2C, 1 picks index 0x2E.
- R9: While engine_busy is high, a data write leaves bits 2:1 of the active select register and bit 0 of index 0x2F unchanged. The write still updates the other bits, and writes to the inactive select register are unaffected.
- R10: Host address 1 holds the configuration index and address 2 reads and writes the indexed register as a full byte. Writing a saved byte back restores the earlier route. Indices other than 0x2C, 0x2E and 0x2F read 0x00, and writes to them are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Host register address: 0 semaphore, 1 config index, 2 config data |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data for host_addr (combinational) |
| mcu_req | input | 1 | Microcontroller bus request (level) |
| mcu_rel | input | 1 | Microcontroller release pulse |
| mcu_grant | output | 1 | Microcontroller owns the bus |
| engine_busy | input | 1 | SMBus engine has a transfer in flight |
| eng_scl_o | input | 1 | Engine clock drive (0 pulls low, 1 releases) |
| eng_sda_o | input | 1 | Engine data drive (0 pulls low, 1 releases) |
| eng_scl_i | output | 1 | Clock level sensed on the selected port |
| eng_sda_i | output | 1 | Data level sensed on the selected port |
| port_scl_o | output | 4 | Clock drive per port pair |
| port_sda_o | output | 4 | Data drive per port pair |
| port_scl_i | input | 4 | Clock level sensed per port pair |
| port_sda_i | input | 4 | Data level sensed per port pair |
| port_sel_o | output | 2 | Active routing code |
| phys_port_o | output | 3 | Physical port number of the active route |

## Verification
On every cycle, the assertions check the following:
- The ownership rules: the microcontroller wins a free bus, either owner holds until it releases, and a host release frees the bus.
- At most one port pair is ever driven low, and all ports are released when the engine is idle.
- The route stays frozen while the engine is busy.
- The unused physical number never appears.

Only the bench scenarios show the rest:
- The readback encoding of the semaphore bit.
- The mapping of select codes to physical numbers through both select registers.
- The byte-level effect of a write made while busy.
- The save-and-restore sequence.

// File: rtl/smb_share_pkg.sv
package smb_share_pkg;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_HOST = 2'd1,
    OWN_MCU  = 2'd2
  } owner_e;

  // host register addresses
  localparam logic [1:0] HA_SEMA  = 2'd0;
  localparam logic [1:0] HA_INDEX = 2'd1;
  localparam logic [1:0] HA_DATA  = 2'd2;

  // semaphore register bits
  localparam int SEMA_REQ_BIT = 4;
  localparam int SEMA_REL_BIT = 5;

  // configuration indices
  localparam logic [7:0] CFG_SEL_A  = 8'h2C;
  localparam logic [7:0] CFG_SEL_B  = 8'h2E;
  localparam logic [7:0] CFG_CHOOSE = 8'h2F;

endpackage

// File: rtl/smb_sema.sv
module smb_sema
  import smb_share_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic host_rel,
  input  logic mcu_req,
  input  logic mcu_rel,
  output logic host_owns,
  output logic mcu_owns
);

  owner_e owner_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_FREE;
    end else begin
      unique case (owner_q)
        OWN_FREE: begin
          if (mcu_req)                    owner_q <= OWN_MCU;
          else if (host_req && !host_rel) owner_q <= OWN_HOST;
        end
        OWN_HOST: if (host_rel) owner_q <= OWN_FREE;
        OWN_MCU:  if (mcu_rel)  owner_q <= OWN_FREE;
        default:  owner_q <= OWN_FREE;
      endcase
    end
  end

  assign host_owns = (owner_q == OWN_HOST);
  assign mcu_owns  = (owner_q == OWN_MCU);

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_share_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FIELD_LSB = 1,
  localparam int SEL_W = $clog2(NUM_PORTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic             busy,
  output logic [7:0]       index_q,
  output logic [7:0]       cfg_rdata,
  output logic [SEL_W-1:0] sel_code
);

  localparam logic [7:0] FIELD_MASK = 8'(((1 << SEL_W) - 1) << FIELD_LSB);

  logic [7:0] sel_a_q, sel_b_q, choose_q;
  logic       use_b;
  logic       data_wr;

  assign use_b   = choose_q[0];
  assign data_wr = wr_en && (wr_addr == HA_DATA);

  // merge keeps the route field when the write targets the live register during a transfer
  function automatic logic [7:0] guarded(input logic [7:0] old_v,
                                         input logic [7:0] new_v,
                                         input logic       lock);
    return lock ? ((new_v & ~FIELD_MASK) | (old_v & FIELD_MASK)) : new_v;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q  <= '0;
      sel_a_q  <= '0;
      sel_b_q  <= '0;
      choose_q <= '0;
    end else begin
      if (wr_en && (wr_addr == HA_INDEX)) index_q <= wr_data;
      if (data_wr) begin
        unique case (index_q)
          CFG_SEL_A:  sel_a_q  <= guarded(sel_a_q, wr_data, busy && !use_b);
          CFG_SEL_B:  sel_b_q  <= guarded(sel_b_q, wr_data, busy && use_b);
          CFG_CHOOSE: choose_q <= busy ? {wr_data[7:1], choose_q[0]} : wr_data;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (index_q)
      CFG_SEL_A:  cfg_rdata = sel_a_q;
      CFG_SEL_B:  cfg_rdata = sel_b_q;
      CFG_CHOOSE: cfg_rdata = choose_q;
      default:    cfg_rdata = 8'h00;
    endcase
  end

  assign sel_code = use_b ? sel_b_q[FIELD_LSB +: SEL_W] : sel_a_q[FIELD_LSB +: SEL_W];

endmodule

// File: rtl/smb_port_mux.sv
module smb_port_mux #(
  parameter int NUM_PORTS = 4,
  localparam int SEL_W  = $clog2(NUM_PORTS),
  localparam int PHYS_W = $clog2(NUM_PORTS + 1)
) (
  input  logic [SEL_W-1:0]     sel,
  input  logic                 eng_scl_o,
  input  logic                 eng_sda_o,
  output logic                 eng_scl_i,
  output logic                 eng_sda_i,
  output logic [NUM_PORTS-1:0] port_scl_o,
  output logic [NUM_PORTS-1:0] port_sda_o,
  input  logic [NUM_PORTS-1:0] port_scl_i,
  input  logic [NUM_PORTS-1:0] port_sda_i,
  output logic [PHYS_W-1:0]    phys_port
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic hit;
    assign hit           = (sel == SEL_W'(p));
    assign port_scl_o[p] = hit ? eng_scl_o : 1'b1;
    assign port_sda_o[p] = hit ? eng_sda_o : 1'b1;
  end

  assign eng_scl_i = port_scl_i[sel];
  assign eng_sda_i = port_sda_i[sel];

  // physical slot 1 is the auxiliary controller, so nonzero codes skip it
  assign phys_port = (sel == '0) ? '0 : (PHYS_W'(sel) + PHYS_W'(1));

endmodule

// File: rtl/smb_share_mux.sv
module smb_share_mux
  import smb_share_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int FIELD_LSB = 1,
  localparam int SEL_W  = $clog2(NUM_PORTS),
  localparam int PHYS_W = $clog2(NUM_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic [1:0]           host_addr,
  input  logic [7:0]           host_wdata,
  output logic [7:0]           host_rdata,
  input  logic                 mcu_req,
  input  logic                 mcu_rel,
  output logic                 mcu_grant,
  input  logic                 engine_busy,
  input  logic                 eng_scl_o,
  input  logic                 eng_sda_o,
  output logic                 eng_scl_i,
  output logic                 eng_sda_i,
  output logic [NUM_PORTS-1:0] port_scl_o,
  output logic [NUM_PORTS-1:0] port_sda_o,
  input  logic [NUM_PORTS-1:0] port_scl_i,
  input  logic [NUM_PORTS-1:0] port_sda_i,
  output logic [SEL_W-1:0]     port_sel_o,
  output logic [PHYS_W-1:0]    phys_port_o
);

  logic       sema_wr;
  logic       host_owns;
  logic [7:0] index_q;
  logic [7:0] cfg_rdata;

  assign sema_wr = host_wr && (host_addr == HA_SEMA);

  smb_sema u_sema (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_req  (sema_wr && host_wdata[SEMA_REQ_BIT]),
    .host_rel  (sema_wr && host_wdata[SEMA_REL_BIT]),
    .mcu_req   (mcu_req),
    .mcu_rel   (mcu_rel),
    .host_owns (host_owns),
    .mcu_owns  (mcu_grant)
  );

  smb_cfg_regs #(.NUM_PORTS(NUM_PORTS), .FIELD_LSB(FIELD_LSB)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (host_wr),
    .wr_addr   (host_addr),
    .wr_data   (host_wdata),
    .busy      (engine_busy),
    .index_q   (index_q),
    .cfg_rdata (cfg_rdata),
    .sel_code  (port_sel_o)
  );

  smb_port_mux #(.NUM_PORTS(NUM_PORTS)) u_mux (
    .sel        (port_sel_o),
    .eng_scl_o  (eng_scl_o),
    .eng_sda_o  (eng_sda_o),
    .eng_scl_i  (eng_scl_i),
    .eng_sda_i  (eng_sda_i),
    .port_scl_o (port_scl_o),
    .port_sda_o (port_sda_o),
    .port_scl_i (port_scl_i),
    .port_sda_i (port_sda_i),
    .phys_port  (phys_port_o)
  );

  always_comb begin
    unique case (host_addr)
      HA_SEMA:  host_rdata = 8'(host_owns) << SEMA_REQ_BIT;
      HA_INDEX: host_rdata = index_q;
      HA_DATA:  host_rdata = cfg_rdata;
      default:  host_rdata = 8'h00;
    endcase
  end

endmodule

// File: rtl/smb_share_mux_chk.sv
module smb_share_mux_chk
  import smb_share_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int SEL_W  = $clog2(NUM_PORTS),
  localparam int PHYS_W = $clog2(NUM_PORTS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 mcu_req,
  input logic                 mcu_rel,
  input logic                 mcu_grant,
  input logic                 host_owns,
  input logic                 host_wr,
  input logic [1:0]           host_addr,
  input logic                 host_rel_bit,
  input logic                 engine_busy,
  input logic                 eng_scl_o,
  input logic                 eng_sda_o,
  input logic [NUM_PORTS-1:0] port_scl_o,
  input logic [NUM_PORTS-1:0] port_sda_o,
  input logic [SEL_W-1:0]     port_sel_o,
  input logic [PHYS_W-1:0]    phys_port_o
);

  logic host_rel_wr;
  assign host_rel_wr = host_wr && (host_addr == HA_SEMA) && host_rel_bit;

  AST_HOST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_owns && host_rel_wr) |=> !host_owns); // R3

  AST_MCU_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcu_grant && !host_owns && mcu_req) |=> (mcu_grant && !host_owns)); // R4

  AST_MCU_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_grant && !mcu_rel) |=> mcu_grant); // R5

  AST_HOST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_owns && !host_rel_wr) |=> host_owns); // R5

  AST_NO_AUX_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    phys_port_o != PHYS_W'(1)); // R6

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_scl_o && eng_sda_o) |-> (&port_scl_o && &port_sda_o)); // R7

  AST_SINGLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(~port_scl_o) <= 1) && ($countones(~port_sda_o) <= 1)); // R7

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    engine_busy |=> $stable(port_sel_o)); // R9

endmodule

bind smb_share_mux smb_share_mux_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .mcu_req      (mcu_req),
  .mcu_rel      (mcu_rel),
  .mcu_grant    (mcu_grant),
  .host_owns    (host_owns),
  .host_wr      (host_wr),
  .host_addr    (host_addr),
  .host_rel_bit (host_wdata[5]),
  .engine_busy  (engine_busy),
  .eng_scl_o    (eng_scl_o),
  .eng_sda_o    (eng_sda_o),
  .port_scl_o   (port_scl_o),
  .port_sda_o   (port_sda_o),
  .port_sel_o   (port_sel_o),
  .phys_port_o  (phys_port_o)
);

// File: tb/tb_smb_share_mux.sv
module tb_smb_share_mux;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       mcu_req = 1'b0, mcu_rel = 1'b0, mcu_grant;
  logic       engine_busy = 1'b0;
  logic       eng_scl_o = 1'b1, eng_sda_o = 1'b1;
  logic       eng_scl_i, eng_sda_i;
  logic [3:0] port_scl_o, port_sda_o;
  logic [3:0] port_scl_i = 4'hF, port_sda_i = 4'hF;
  logic [1:0] port_sel_o;
  logic [2:0] phys_port_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  smb_share_mux dut (.*);

  // vector: bit6 = select register choice, bits5:4 = code, bits2:0 = expected physical port
  localparam logic [7:0] VEC [7] = '{8'h00, 8'h12, 8'h23, 8'h34, 8'h63, 8'h52, 8'h74};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] v);
    wr(2'd1, idx);
    wr(2'd2, v);
  endtask

  task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
    wr(2'd1, idx);
    rd(2'd2, d);
  endtask

  task automatic mcu_pulse(input logic rq, input logic rl);
    @(negedge clk);
    mcu_req = rq; mcu_rel = rl;
    @(negedge clk);
    mcu_req = 1'b0; mcu_rel = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d, saved;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d);             check("R1 sema", d, 8'h00);
    check("R1 mcu_grant", mcu_grant, 0);
    check("R1 port_sel", port_sel_o, 0);
    check("R1 phys", phys_port_o, 0);
    check("R1 scl", port_scl_o, 4'hF);
    check("R1 sda", port_sda_o, 4'hF);

    // R6 R7 R8 table walk
    for (int i = 0; i < 7; i++) begin
      logic       alt;
      logic [1:0] code;
      logic [2:0] ph;
      logic [7:0] pick, other, val;
      alt  = VEC[i][6];
      code = VEC[i][5:4];
      ph   = VEC[i][2:0];
      pick  = alt ? 8'h2E : 8'h2C;
      other = alt ? 8'h2C : 8'h2E;
      val   = 8'hA1 | {5'b0, code, 1'b0};
      cfg_wr(8'h2F, {7'b0, alt});
      cfg_wr(pick, val);
      cfg_wr(other, {5'b0, ~code, 1'b0});
      check("R8 port_sel", port_sel_o, code);
      check("R6 phys", phys_port_o, ph);
      cfg_rd(pick, d);
      check("R10 readback", d, val);
      eng_scl_o = 1'b0; eng_sda_o = 1'b0;
      port_scl_i = 4'b1010; port_sda_i = 4'b0110;
      #0.5;
      check("R7 scl_o", port_scl_o, 4'hF & ~(4'b1 << code));
      check("R7 sda_o", port_sda_o, 4'hF & ~(4'b1 << code));
      check("R7 scl_i", eng_scl_i, port_scl_i[code]);
      check("R7 sda_i", eng_sda_i, port_sda_i[code]);
      eng_scl_o = 1'b1; eng_sda_o = 1'b1;
    end

    // R10 save, rewrite, restore; unknown index
    cfg_wr(8'h2F, 8'h00);
    cfg_rd(8'h2C, saved);
    cfg_wr(8'h2C, 8'h5B);
    check("R10 rewrite sel", port_sel_o, 2'd1);
    cfg_rd(8'h2C, d);        check("R10 rewrite byte", d, 8'h5B);
    cfg_wr(8'h2C, saved);
    check("R10 restore sel", port_sel_o, saved[2:1]);
    cfg_rd(8'h2C, d);        check("R10 restore byte", d, saved);
    cfg_wr(8'h30, 8'hFF);
    cfg_rd(8'h30, d);        check("R10 unknown idx", d, 8'h00);

    // R9 busy guard
    cfg_wr(8'h2C, 8'h02);
    check("R9 pre sel", port_sel_o, 2'd1);
    engine_busy = 1'b1;
    cfg_wr(8'h2C, 8'hF6);
    check("R9 busy sel", port_sel_o, 2'd1);
    cfg_rd(8'h2C, d);        check("R9 busy byte", d, 8'hF2);
    cfg_wr(8'h2F, 8'h01);
    cfg_rd(8'h2F, d);        check("R9 busy choose", d, 8'h00);
    check("R9 busy sel2", port_sel_o, 2'd1);
    cfg_wr(8'h2E, 8'h04);
    cfg_rd(8'h2E, d);        check("R9 inactive reg", d, 8'h04);
    engine_busy = 1'b0;
    cfg_wr(8'h2C, 8'hF6);
    check("R9 idle sel", port_sel_o, 2'd3);
    check("R6 idle phys", phys_port_o, 3'd4);

    // R2 host request and readback
    wr(2'd0, 8'h10);
    rd(2'd0, d);             check("R2 host granted", d, 8'h10);
    // R5 mcu ignored while host owns
    mcu_pulse(1'b1, 1'b0);
    check("R5 mcu blocked", mcu_grant, 0);
    rd(2'd0, d);             check("R5 host kept", d, 8'h10);
    // R3 release
    wr(2'd0, 8'h20);
    rd(2'd0, d);             check("R3 host released", d, 8'h00);
    // R3 both bits: release wins
    wr(2'd0, 8'h30);
    rd(2'd0, d);             check("R3 both bits", d, 8'h00);
    // R4 mcu takes free bus
    mcu_pulse(1'b1, 1'b0);
    check("R4 mcu grant", mcu_grant, 1);
    // R5 host ignored while mcu owns
    wr(2'd0, 8'h10);
    rd(2'd0, d);             check("R5 host blocked", d, 8'h00);
    check("R5 mcu held", mcu_grant, 1);
    mcu_pulse(1'b0, 1'b1);
    check("R5 mcu released", mcu_grant, 0);
    // R4 same-cycle contention
    @(negedge clk);
    mcu_req = 1'b1; host_wr = 1'b1; host_addr = 2'd0; host_wdata = 8'h10;
    @(negedge clk);
    mcu_req = 1'b0; host_wr = 1'b0;
    check("R4 tie mcu", mcu_grant, 1);
    rd(2'd0, d);             check("R4 tie host", d, 8'h00);
    mcu_pulse(1'b0, 1'b1);
    wr(2'd0, 8'h10);
    rd(2'd0, d);             check("R2 host after free", d, 8'h10);

    summary();
    $finish;
  end

endmodule